// File: doc/BRIEF.md
# Output-Stationary 1-D Convolution Unit

This unit computes a valid-mode 1-D convolution. An activation vector of length H is slid against an R-tap signed weight vector, which yields H - R + 1 results. Each result is built in one local accumulator register across all of its taps. The finished sum goes straight to an output buffer, so that buffer is never read back and each result location is written exactly once.

Activations and weights sit in two small external buffers with synchronous read ports: the address presented in one cycle returns its data in the next. A single-cycle `start` with legal lengths launches a run. The unit then walks every (output, tap) pair at one pair per cycle with no stalls between outputs, and pulses `done` when the run is over. Four running tallies report how many weight reads, activation reads, output reads and output writes the last run made, so the traffic of this schedule can be measured against its expected figures.

Top module: `os_conv1d`

## Requirements
- R1: Out of reset `busy`, `done`, `inRe`, `wtRe` and `outWe` are low and all four tallies read zero.
- R2: A legal run writes outputs at addresses 0 to E-1, where E = lenH - lenR + 1. Each address is written exactly once, and the value at address e is the sum over r of act[e+r]*wt[r]. No other address is written.
- R3: Operands are signed two's complement of DATA_W bits. The accumulator is 2*DATA_W + clog2(MAX_R) bits wide, and results stay exact even when every operand is at its most negative or most positive value.
- R4: Reads are issued as one activation/weight pair per cycle. The output index is the outer loop and the tap index the inner one: activation address e+r, weight address r.
- R5: The accumulator starts from zero for every output, both within a run and at the start of a new run.
- R6: If N = E*lenR, then `done` is high in exactly the (N+2)th cycle after the edge that accepts `start`. The last output write happens in the cycle just before it.
- R7: `done` lasts one cycle. A `start` that arrives while `busy` is high does not change the run in progress.
- R8: After a run the weight-read and activation-read tallies both equal E*lenR, the output-read tally is 0, and the output-write tally equals E. All four tallies clear when a new run is accepted.
- R9: A `start` with lenR = 0, lenR > lenH, lenH > MAX_H or lenR > MAX_R is ignored. The unit stays idle, writes nothing and leaves the tallies unchanged.
- R10: With lenH = 12 and lenR = 4 the run yields exactly 9 outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch request, sampled while idle |
| lenH | input | LEN_W | Activation vector length for the run |
| lenR | input | LEN_W | Number of taps for the run |
| busy | output | 1 | Run in progress (includes the done cycle) |
| done | output | 1 | One-cycle end-of-run pulse |
| inRe | output | 1 | Activation buffer read enable |
| inAddr | output | IDX_W | Activation buffer read address |
| inData | input | DATA_W | Activation read data, one cycle after inRe |
| wtRe | output | 1 | Weight buffer read enable |
| wtAddr | output | WIDX_W | Weight buffer read address |
| wtData | input | DATA_W | Weight read data, one cycle after wtRe |
| outWe | output | 1 | Output buffer write enable |
| outAddr | output | IDX_W | Output buffer write address |
| outData | output | ACC_W | Finished output value |
| cntWtRd | output | CNT_W | Weight reads in the last run |
| cntInRd | output | CNT_W | Activation reads in the last run |
| cntOutRd | output | CNT_W | Output-buffer reads in the last run |
| cntOutWr | output | CNT_W | Output-buffer writes in the last run |

## Verification
The bench builds the unit with DATA_W = 8, MAX_H = 16 and MAX_R = 8, which gives a 19-bit accumulator, 5-bit lengths and 4-bit activation addresses. These sizes allow a full-length vector with a single tap (sixteen outputs), a run where taps equal length (one output), and an eight-tap run with all operands at -128 or +127, which brings the accumulator close to its top. The 5-bit length field can also encode lengths one past each maximum, so every kind of illegal launch can be presented.

// File: rtl/os_conv_pkg.sv
package os_conv_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_DRAIN = 2'd2,
    ST_DONE  = 2'd3
  } convState_t;

  // strobes from the sequencer to the arithmetic and tally blocks
  typedef struct packed {
    logic rdEn;        // read pair issued this cycle
    logic macEn;       // operands present, accumulate this cycle
    logic accClear;    // operand belongs to tap 0 of an output
    logic wrEn;        // finished output leaves this cycle
    logic tallyClear;  // run accepted, restart the tallies
  } convStrobe_t;

endpackage

// File: rtl/os_conv_ctrl.sv
module os_conv_ctrl
  import os_conv_pkg::*;
#(
  parameter int MAX_H  = 16,
  parameter int MAX_R  = 8,
  parameter int LEN_W  = 5,
  parameter int IDX_W  = 4,
  parameter int WIDX_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [LEN_W-1:0]  lenH,
  input  logic [LEN_W-1:0]  lenR,
  output logic              busy,
  output logic              done,
  output logic [IDX_W-1:0]  inAddr,
  output logic [WIDX_W-1:0] wtAddr,
  output logic [IDX_W-1:0]  outAddr,
  output convStrobe_t       strobe
);

  convState_t state, stateNext;

  logic [IDX_W-1:0]  eCnt, eLastQ;
  logic [WIDX_W-1:0] rCnt, rLastQ;
  logic              tapLast, outLast, legal, accept, issue;

  // stage 1: operands returning from the buffers
  logic              s1Valid, s1First, s1Last, s1Final;
  logic [IDX_W-1:0]  s1Idx;
  // stage 2: finished output leaving
  logic              wrValid, wrFinal;
  logic [IDX_W-1:0]  wrIdx;

  assign legal = (lenR != '0) && (lenR <= lenH) &&
                 (lenH <= LEN_W'(MAX_H)) && (lenR <= LEN_W'(MAX_R));
  assign accept  = (state == ST_IDLE) && start && legal;
  assign issue   = (state == ST_RUN);
  assign tapLast = (rCnt == rLastQ);
  assign outLast = (eCnt == eLastQ);

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:  if (accept) stateNext = ST_RUN;
      ST_RUN:   if (tapLast && outLast) stateNext = ST_DRAIN;
      ST_DRAIN: if (wrValid && wrFinal) stateNext = ST_DONE;
      ST_DONE:  stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      eCnt   <= '0;
      rCnt   <= '0;
      eLastQ <= '0;
      rLastQ <= '0;
    end else begin
      state <= stateNext;
      if (accept) begin
        eCnt   <= '0;
        rCnt   <= '0;
        eLastQ <= IDX_W'(lenH - lenR);
        rLastQ <= WIDX_W'(lenR - LEN_W'(1));
      end else if (issue) begin
        if (tapLast) begin
          rCnt <= '0;
          if (!outLast) eCnt <= eCnt + IDX_W'(1);
        end else begin
          rCnt <= rCnt + WIDX_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1Valid <= 1'b0;
      s1First <= 1'b0;
      s1Last  <= 1'b0;
      s1Final <= 1'b0;
      s1Idx   <= '0;
      wrValid <= 1'b0;
      wrFinal <= 1'b0;
      wrIdx   <= '0;
    end else begin
      s1Valid <= issue;
      s1First <= issue && (rCnt == '0);
      s1Last  <= issue && tapLast;
      s1Final <= issue && tapLast && outLast;
      s1Idx   <= eCnt;
      wrValid <= s1Valid && s1Last;
      wrFinal <= s1Valid && s1Final;
      wrIdx   <= s1Idx;
    end
  end

  assign inAddr  = eCnt + IDX_W'(rCnt);
  assign wtAddr  = rCnt;
  assign outAddr = wrIdx;
  assign busy    = (state != ST_IDLE);
  assign done    = (state == ST_DONE);

  always_comb begin
    strobe            = '0;
    strobe.rdEn       = issue;
    strobe.macEn      = s1Valid;
    strobe.accClear   = s1First;
    strobe.wrEn       = wrValid;
    strobe.tallyClear = accept;
  end

endmodule

// File: rtl/os_conv_datapath.sv
module os_conv_datapath
  import os_conv_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ACC_W  = 19
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  convStrobe_t              strobe,
  input  logic signed [DATA_W-1:0] inData,
  input  logic signed [DATA_W-1:0] wtData,
  output logic signed [ACC_W-1:0]  outData
);

  localparam int PROD_W = 2 * DATA_W;

  logic signed [PROD_W-1:0] prod;
  logic signed [ACC_W-1:0]  acc, accBase;

  assign prod    = inData * wtData;
  assign accBase = strobe.accClear ? '0 : acc;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) acc <= '0;
    else if (strobe.macEn) acc <= accBase + ACC_W'(prod);
  end

  // the finished sum is held for the write cycle; the next output's
  // first tap overwrites it at the end of that same cycle
  assign outData = acc;

endmodule

// File: rtl/os_conv_tally.sv
module os_conv_tally
  import os_conv_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  convStrobe_t      strobe,
  output logic [CNT_W-1:0] cntWtRd,
  output logic [CNT_W-1:0] cntInRd,
  output logic [CNT_W-1:0] cntOutRd,
  output logic [CNT_W-1:0] cntOutWr
);

  localparam int NUM_TALLY = 4;

  logic [NUM_TALLY-1:0] bump;
  logic [CNT_W-1:0]     tally [NUM_TALLY];

  // the output buffer has no read path, so its read tally never advances
  assign bump = {strobe.wrEn, 1'b0, strobe.rdEn, strobe.rdEn};

  for (genvar k = 0; k < NUM_TALLY; k++) begin : g_tally
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) tally[k] <= '0;
      else if (strobe.tallyClear) tally[k] <= '0;
      else if (bump[k]) tally[k] <= tally[k] + CNT_W'(1);
    end
  end

  assign cntWtRd  = tally[0];
  assign cntInRd  = tally[1];
  assign cntOutRd = tally[2];
  assign cntOutWr = tally[3];

endmodule

// File: rtl/os_conv1d.sv
module os_conv1d
  import os_conv_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int MAX_H  = 16,
  parameter int MAX_R  = 8,
  localparam int LEN_W  = $clog2(MAX_H + 1),
  localparam int IDX_W  = (MAX_H > 1) ? $clog2(MAX_H) : 1,
  localparam int WIDX_W = (MAX_R > 1) ? $clog2(MAX_R) : 1,
  localparam int ACC_W  = 2 * DATA_W + ((MAX_R > 1) ? $clog2(MAX_R) : 1),
  localparam int CNT_W  = $clog2(MAX_H * MAX_R + 1)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     start,
  input  logic [LEN_W-1:0]         lenH,
  input  logic [LEN_W-1:0]         lenR,
  output logic                     busy,
  output logic                     done,
  output logic                     inRe,
  output logic [IDX_W-1:0]         inAddr,
  input  logic signed [DATA_W-1:0] inData,
  output logic                     wtRe,
  output logic [WIDX_W-1:0]        wtAddr,
  input  logic signed [DATA_W-1:0] wtData,
  output logic                     outWe,
  output logic [IDX_W-1:0]         outAddr,
  output logic signed [ACC_W-1:0]  outData,
  output logic [CNT_W-1:0]         cntWtRd,
  output logic [CNT_W-1:0]         cntInRd,
  output logic [CNT_W-1:0]         cntOutRd,
  output logic [CNT_W-1:0]         cntOutWr
);

  convStrobe_t strobe;

  os_conv_ctrl #(
    .MAX_H(MAX_H), .MAX_R(MAX_R), .LEN_W(LEN_W),
    .IDX_W(IDX_W), .WIDX_W(WIDX_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .lenH(lenH), .lenR(lenR),
    .busy(busy), .done(done), .inAddr(inAddr), .wtAddr(wtAddr),
    .outAddr(outAddr), .strobe(strobe)
  );

  os_conv_datapath #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .inData(inData), .wtData(wtData), .outData(outData)
  );

  os_conv_tally #(.CNT_W(CNT_W)) u_tally (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .cntWtRd(cntWtRd), .cntInRd(cntInRd),
    .cntOutRd(cntOutRd), .cntOutWr(cntOutWr)
  );

  assign inRe  = strobe.rdEn;
  assign wtRe  = strobe.rdEn;
  assign outWe = strobe.wrEn;

endmodule

// File: rtl/os_conv1d_chk.sv
module os_conv1d_chk #(
  parameter int MAX_H  = 16,
  parameter int MAX_R  = 8,
  parameter int LEN_W  = 5,
  parameter int IDX_W  = 4,
  parameter int WIDX_W = 3,
  parameter int CNT_W  = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic [LEN_W-1:0]  lenH,
  input logic [LEN_W-1:0]  lenR,
  input logic              busy,
  input logic              done,
  input logic              inRe,
  input logic [IDX_W-1:0]  inAddr,
  input logic              wtRe,
  input logic [WIDX_W-1:0] wtAddr,
  input logic              outWe,
  input logic [IDX_W-1:0]  outAddr,
  input logic [CNT_W-1:0]  cntOutWr
);

  logic             okLen;
  logic [LEN_W-1:0] hSeen, rSeen, eSeen;

  assign okLen = (lenR != '0) && (lenR <= lenH) &&
                 (lenH <= LEN_W'(MAX_H)) && (lenR <= LEN_W'(MAX_R));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hSeen <= '0;
      rSeen <= '0;
      eSeen <= '0;
    end else if (start && !busy && okLen) begin
      hSeen <= lenH;
      rSeen <= lenR;
      eSeen <= lenH - lenR + LEN_W'(1);
    end
  end

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!inRe && !wtRe && !outWe && !done));

  assert_final_write_R6: assert property (@(posedge clk) disable iff (!rstN)
    done |-> ($past(outWe) && (LEN_W'($past(outAddr)) == eSeen - LEN_W'(1))));

  assert_rd_range_R4: assert property (@(posedge clk) disable iff (!rstN)
    inRe |-> ((LEN_W'(inAddr) < hSeen) && (LEN_W'(wtAddr) < rSeen)));

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_busy_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done && start) |=> busy);

  assert_write_tally_R8: assert property (@(posedge clk) disable iff (!rstN)
    outWe |=> (cntOutWr == $past(cntOutWr) + CNT_W'(1)));

  assert_illegal_ignored_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && start && !okLen) |=> !busy);

endmodule

bind os_conv1d os_conv1d_chk #(
  .MAX_H(MAX_H), .MAX_R(MAX_R), .LEN_W(LEN_W),
  .IDX_W(IDX_W), .WIDX_W(WIDX_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rstN(rstN), .start(start), .lenH(lenH), .lenR(lenR),
  .busy(busy), .done(done), .inRe(inRe), .inAddr(inAddr),
  .wtRe(wtRe), .wtAddr(wtAddr), .outWe(outWe), .outAddr(outAddr),
  .cntOutWr(cntOutWr)
);

// File: tb/tb_os_conv1d.sv
module tb_os_conv1d;

  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 8;
  localparam int MAX_H  = 16;
  localparam int MAX_R  = 8;
  localparam int LEN_W  = 5;
  localparam int IDX_W  = 4;
  localparam int WIDX_W = 3;
  localparam int ACC_W  = 19;
  localparam int CNT_W  = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [LEN_W-1:0] lenH = '0, lenR = '0;
  logic busy, done, inRe, wtRe, outWe;
  logic [IDX_W-1:0] inAddr, outAddr;
  logic [WIDX_W-1:0] wtAddr;
  logic signed [DATA_W-1:0] inQ = '0, wtQ = '0;
  logic signed [ACC_W-1:0] outData;
  logic [CNT_W-1:0] cntWtRd, cntInRd, cntOutRd, cntOutWr;

  logic signed [DATA_W-1:0] inMem [MAX_H];
  logic signed [DATA_W-1:0] wtMem [MAX_R];
  logic signed [ACC_W-1:0]  outMem [MAX_H];
  int wrHits [MAX_H];
  int issued, ordE, ordR, ordErr, curR, wrTotal;
  int total = 0, bad = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  os_conv1d #(.DATA_W(DATA_W), .MAX_H(MAX_H), .MAX_R(MAX_R)) dut (
    .clk(clk), .rstN(rstN), .start(start), .lenH(lenH), .lenR(lenR),
    .busy(busy), .done(done), .inRe(inRe), .inAddr(inAddr), .inData(inQ),
    .wtRe(wtRe), .wtAddr(wtAddr), .wtData(wtQ), .outWe(outWe),
    .outAddr(outAddr), .outData(outData), .cntWtRd(cntWtRd),
    .cntInRd(cntInRd), .cntOutRd(cntOutRd), .cntOutWr(cntOutWr)
  );

  // buffer models with one-cycle read latency, plus an issue-order monitor
  always @(posedge clk) begin
    if (inRe) inQ <= inMem[inAddr];
    if (wtRe) wtQ <= wtMem[wtAddr];
    if (outWe) begin
      outMem[outAddr] <= outData;
      wrHits[outAddr] = wrHits[outAddr] + 1;
      wrTotal = wrTotal + 1;
    end
    if (inRe) begin
      issued = issued + 1;
      if (int'(inAddr) != ordE + ordR || int'(wtAddr) != ordR || !wtRe)
        ordErr = ordErr + 1;
      ordR = ordR + 1;
      if (ordR >= curR) begin
        ordR = 0;
        ordE = ordE + 1;
      end
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic fillData(input int seed, input int mode);
    for (int i = 0; i < MAX_H; i++) begin
      if (mode == 1) inMem[i] = -128;
      else if (mode == 2) inMem[i] = 127;
      else inMem[i] = DATA_W'(((i * 37 + seed * 11) % 256) - 128);
    end
    for (int i = 0; i < MAX_R; i++) begin
      if (mode == 1) wtMem[i] = -128;
      else if (mode == 2) wtMem[i] = -128;
      else wtMem[i] = DATA_W'(((i * 53 + seed * 29 + 7) % 256) - 128);
    end
  endtask

  // launches one run and checks outputs, order, timing and tallies;
  // poke != 0 pulses start with other lengths in the middle of the run
  task automatic runConv(input int h, input int r, input int poke, input string tag);
    int n, e, nPairs;
    longint sum;
    e = h - r + 1;
    nPairs = e * r;
    for (int i = 0; i < MAX_H; i++) begin
      wrHits[i] = 0;
      outMem[i] = '0;
    end
    issued = 0; ordE = 0; ordR = 0; ordErr = 0; curR = r; wrTotal = 0;
    @(negedge clk);
    lenH = LEN_W'(h);
    lenR = LEN_W'(r);
    start = 1'b1;
    n = 0;
    while (n < 400) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      start = 1'b0;
      if (poke != 0 && n == 4) begin
        start = 1'b1;
        lenH = LEN_W'(5);
        lenR = LEN_W'(2);
      end
      if (done) break;
    end
    start = 1'b0;
    // R6: done in the (N+2)th cycle after acceptance
    check(n == nPairs + 3, {"R6 done timing ", tag}, n, nPairs + 3);
    @(negedge clk);
    check(!done && !busy, {"R7 done single cycle ", tag}, done, 0);
    // R2 / R5: values and single writes
    for (int k = 0; k < MAX_H; k++) begin
      if (k < e) begin
        sum = 0;
        for (int t = 0; t < r; t++) sum += longint'(inMem[k + t]) * longint'(wtMem[t]);
        check(longint'(outMem[k]) == sum, {"R2 R5 output value ", tag}, outMem[k], sum);
        check(wrHits[k] == 1, {"R2 write once ", tag}, wrHits[k], 1);
      end else begin
        check(wrHits[k] == 0, {"R2 no stray write ", tag}, wrHits[k], 0);
      end
    end
    // R4: issue order
    check(ordErr == 0 && issued == nPairs, {"R4 issue order ", tag}, ordErr, 0);
    // R8: tallies
    check(int'(cntWtRd) == nPairs, {"R8 weight reads ", tag}, cntWtRd, nPairs);
    check(int'(cntInRd) == nPairs, {"R8 input reads ", tag}, cntInRd, nPairs);
    check(cntOutRd == '0, {"R8 output reads ", tag}, cntOutRd, 0);
    check(int'(cntOutWr) == e, {"R8 output writes ", tag}, cntOutWr, e);
  endtask

  task automatic tryIllegal(input int h, input int r, input string tag);
    logic [CNT_W-1:0] wBefore, oBefore;
    bit sawBusy;
    wBefore = cntWtRd;
    oBefore = cntOutWr;
    wrTotal = 0;
    sawBusy = 0;
    @(negedge clk);
    lenH = LEN_W'(h);
    lenR = LEN_W'(r);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 6; i++) begin
      if (busy) sawBusy = 1;
      @(negedge clk);
    end
    check(!sawBusy, {"R9 stays idle ", tag}, sawBusy, 0);
    check(wrTotal == 0, {"R9 no writes ", tag}, wrTotal, 0);
    check(cntWtRd == wBefore && cntOutWr == oBefore, {"R9 tallies kept ", tag},
          cntWtRd, wBefore);
  endtask

  task automatic testReset();
    @(negedge clk);
    check(!busy && !done && !inRe && !wtRe && !outWe, "R1 idle outputs",
          {busy, done, inRe, wtRe, outWe}, 0);
    check(cntWtRd == '0 && cntInRd == '0 && cntOutRd == '0 && cntOutWr == '0,
          "R1 tallies zero", cntWtRd + cntInRd + cntOutWr, 0);
  endtask

  task automatic testReference();
    fillData(3, 0);
    runConv(12, 4, 0, "ref12x4");
    check(int'(cntOutWr) == 9, "R10 nine outputs", cntOutWr, 9);
  endtask

  task automatic testShapes();
    fillData(5, 0);
    runConv(16, 1, 0, "single tap");
    fillData(9, 0);
    runConv(8, 8, 0, "taps equal length");
    runConv(16, 8, 0, "max sizes");
  endtask

  task automatic testExtremes();
    fillData(0, 1);
    runConv(16, 8, 0, "R3 all most negative");
    fillData(0, 2);
    runConv(16, 8, 0, "R3 mixed extremes");
  endtask

  task automatic testBackToBack();
    // small values right after the large extreme run: stale sums would show
    fillData(1, 0);
    for (int i = 0; i < MAX_H; i++) inMem[i] = DATA_W'(i - 3);
    runConv(6, 3, 0, "R5 after large run");
    runConv(7, 2, 0, "R5 R8 second back to back");
  endtask

  task automatic testStartWhileBusy();
    fillData(12, 0);
    runConv(10, 3, 1, "R7 start while busy");
  endtask

  task automatic testIllegal();
    tryIllegal(6, 0, "taps zero");
    tryIllegal(4, 5, "taps exceed length");
    tryIllegal(17, 2, "length over max");
    tryIllegal(12, 9, "taps over max");
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < MAX_H; i++) wrHits[i] = 0;
    issued = 0; ordE = 0; ordR = 0; ordErr = 0; curR = 1; wrTotal = 0;
    fillData(0, 0);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testReference();
    testShapes();
    testExtremes();
    testBackToBack();
    testStartWhileBusy();
    testIllegal();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule